// File: doc/BRIEF.md
# Pending Interrupt Scan and Dispatch

This block collects interrupt requests arriving as pin-number pulses into a vector of pending flags, one flag per implemented pin. A service pass walks the pins one per clock in ascending order. Each pending pin whose redirection entry is not masked is turned into a delivery message, built from that entry's fields. The message is offered to a downstream receiver for exactly one cycle.

The receiver answers in the same cycle with a ready level. Acceptance clears the pin's pending flag. Refusal leaves the flag set, so the request is retried on a later pass. Masked pins keep their flag and are skipped. The redirection table sits outside the block: the block drives a table index and reads back the addressed 64-bit entry in the same cycle. It also presents that entry in a form fit for software readback, with the delivery-status bit forced to idle.

Top module: `irq_dispatch`

## Requirements
- R1: After reset every pending flag is 0, `msgValid` is 0 and the block is idle.
- R2: A pulse on `trigValid` with `trigPin` below `NUM_PINS` sets pending flag `trigPin` at the next clock edge. Pulsing a pin whose flag is already set leaves the flags unchanged.
- R3: A pulse with `trigPin` at or above `NUM_PINS` changes no pending flag and starts no pass.
- R4: A pass starts when `serviceReq` is high or when a trigger sets a flag that was clear. A pass visits pins 0 to `NUM_PINS-1` in ascending order, one pin per cycle, and spends one extra cycle on each pin it offers.
- R5: A start request that arrives while a pass runs causes one more complete pass from pin 0 once the current pass ends.
- R6: A message carries fields of the addressed entry: `msgDest` from bits 63:56, `msgDestMode` from bit 11, `msgDelMode` from bits 10:8, `msgVector` from bits 7:0, `msgPolarity` from bit 13 and `msgTrigMode` from bit 15.
- R7: A pin whose entry has bit 16 set (masked) is never offered, and its pending flag stays set.
- R8: `msgValid` is high for exactly one cycle per offer. The pin's flag is cleared only if `msgReady` is high in that cycle. Otherwise the flag stays set.
- R9: A trigger for a pin in the same cycle that the pin's flag is cleared by acceptance leaves the flag set.
- R10: `entryView` equals `tblEntry` with bit 12 forced to 0.
- R11: With `msgReady` held high and no new triggers, one service request delivers every unmasked pending pin and leaves only masked pins pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | Trigger pulse for `trigPin` |
| trigPin | input | PIN_W | Pin number of the trigger |
| serviceReq | input | 1 | Request for a service pass |
| tblIdx | output | PIN_W | Redirection table index being read |
| tblEntry | input | 64 | Redirection entry at `tblIdx`, same cycle |
| entryView | output | 64 | Readback form of `tblEntry`, status bit cleared |
| pendingOut | output | NUM_PINS | Pending flag vector |
| msgValid | output | 1 | Delivery message offered this cycle |
| msgReady | input | 1 | Receiver accepts the offered message |
| msgDest | output | 8 | Destination field |
| msgDestMode | output | 1 | Destination mode |
| msgDelMode | output | 3 | Delivery mode |
| msgVector | output | 8 | Interrupt vector |
| msgPolarity | output | 1 | Input polarity |
| msgTrigMode | output | 1 | Trigger mode |

## Verification
The bench starts deliveries while the receiver refuses them and checks that the refused pins stay pending and are later delivered in ascending pin order, at the exact cycles one-pin-per-cycle scanning predicts. A design that cleared on offer would lose those pins, and one that scanned in another order would show the wrong order or timing. Other directed cases cover these errors:
- Dropping a service request made mid-pass strands a pin that was unmasked after the scan had passed it.
- Letting a clear beat a same-cycle trigger loses the second request.
- Treating an out-of-range pin number modulo the width sets a real flag.

Random traffic, with random acceptance, is checked every cycle against a model of the pending vector.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam int ENTRY_W    = 64;
  localparam int MASK_BIT   = 16;
  localparam int STATUS_BIT = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SEND = 2'd2
  } scanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMsg;
    logic clearPend;
  } dpStrobe_t;

  typedef struct packed {
    logic [7:0] dest;
    logic       destMode;
    logic [2:0] delMode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigMode;
  } dlvMsg_t;

  function automatic dlvMsg_t decodeEntry(input logic [ENTRY_W-1:0] e);
    dlvMsg_t m;
    m.dest     = e[63:56];
    m.destMode = e[11];
    m.delMode  = e[10:8];
    m.vector   = e[7:0];
    m.polarity = e[13];
    m.trigMode = e[15];
    return m;
  endfunction

endpackage

// File: rtl/irqd_datapath.sv
module irqd_datapath
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigValid,
  input  logic [PIN_W-1:0]    trigPin,
  input  logic                serviceReq,
  input  logic [PIN_W-1:0]    scanIdx,
  input  dpStrobe_t           strb,
  input  logic [ENTRY_W-1:0]  tblEntry,
  output logic                kick,
  output logic                hit,
  output logic [NUM_PINS-1:0] pending,
  output dlvMsg_t             msg,
  output logic [ENTRY_W-1:0]  entryView
);

  logic [NUM_PINS-1:0] setMask;
  logic [NUM_PINS-1:0] selMask;
  logic [NUM_PINS-1:0] clrMask;

  // pin decoders; an out-of-range pin number matches no bit
  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    assign setMask[gi] = trigValid && (trigPin == PIN_W'(gi));
    assign selMask[gi] = (scanIdx == PIN_W'(gi));
    assign clrMask[gi] = strb.clearPend && selMask[gi];
  end

  assign kick      = serviceReq || (|(setMask & ~pending));
  assign hit       = (|(pending & selMask)) && !tblEntry[MASK_BIT];
  assign entryView = tblEntry & ~(ENTRY_W'(1) << STATUS_BIT);

  // a same-cycle set overrides the clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else begin
      pending <= (pending & ~clrMask) | setMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msg <= '0;
    end else if (strb.loadMsg) begin
      msg <= decodeEntry(tblEntry);
    end
  end

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearPend |=> (($past(pending) & ~pending) == '0)); // R8

  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    trigValid |=> ((pending & $past(setMask)) == $past(setMask))); // R9

  AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid && (32'(trigPin) >= NUM_PINS) && !strb.clearPend)
      |=> (pending == $past(pending))); // R3

endmodule

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             kick,
  input  logic             hit,
  input  logic             msgReady,
  output dpStrobe_t        strb,
  output logic [PIN_W-1:0] scanIdx,
  output logic             msgValid
);

  localparam logic [PIN_W-1:0] LAST_IDX = PIN_W'(NUM_PINS - 1);

  scanState_e state;
  logic       rerun;
  logic       advance;
  logic       lastPin;

  always_comb begin
    msgValid       = (state == ST_SEND);
    strb.loadMsg   = (state == ST_SCAN) && hit;
    strb.clearPend = msgValid && msgReady;
    advance        = ((state == ST_SCAN) && !hit) || msgValid;
    lastPin        = (scanIdx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
      rerun   <= 1'b0;
    end else if (state == ST_IDLE) begin
      rerun <= 1'b0;
      if (kick) begin
        state   <= ST_SCAN;
        scanIdx <= '0;
      end
    end else if (advance && lastPin) begin
      rerun <= 1'b0;
      if (rerun || kick) begin
        state   <= ST_SCAN;
        scanIdx <= '0;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      if (kick) rerun <= 1'b1;
      if (advance) begin
        state   <= ST_SCAN;
        scanIdx <= scanIdx + 1'b1;
      end else begin
        state <= ST_SEND;
      end
    end
  end

  AST_ONE_SHOT_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |=> !msgValid); // R8

  AST_OFFER_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(hit)); // R7

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    32'(scanIdx) < NUM_PINS); // R4

  AST_SCAN_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && advance && !lastPin)
      |=> (scanIdx == $past(scanIdx) + 1'b1)); // R4

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigValid,
  input  logic [PIN_W-1:0]    trigPin,
  input  logic                serviceReq,
  output logic [PIN_W-1:0]    tblIdx,
  input  logic [63:0]         tblEntry,
  output logic [63:0]         entryView,
  output logic [NUM_PINS-1:0] pendingOut,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [7:0]          msgDest,
  output logic                msgDestMode,
  output logic [2:0]          msgDelMode,
  output logic [7:0]          msgVector,
  output logic                msgPolarity,
  output logic                msgTrigMode
);

  dpStrobe_t        strb;
  dlvMsg_t          msg;
  logic             kick;
  logic             hit;
  logic [PIN_W-1:0] scanIdx;

  irqd_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .kick     (kick),
    .hit      (hit),
    .msgReady (msgReady),
    .strb     (strb),
    .scanIdx  (scanIdx),
    .msgValid (msgValid)
  );

  irqd_datapath #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .trigValid  (trigValid),
    .trigPin    (trigPin),
    .serviceReq (serviceReq),
    .scanIdx    (scanIdx),
    .strb       (strb),
    .tblEntry   (tblEntry),
    .kick       (kick),
    .hit        (hit),
    .pending    (pendingOut),
    .msg        (msg),
    .entryView  (entryView)
  );

  assign tblIdx      = scanIdx;
  assign msgDest     = msg.dest;
  assign msgDestMode = msg.destMode;
  assign msgDelMode  = msg.delMode;
  assign msgVector   = msg.vector;
  assign msgPolarity = msg.polarity;
  assign msgTrigMode = msg.trigMode;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!msgValid && (pendingOut == '0))); // R1

endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;

  localparam int NP = 24;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          trigValid = 1'b0;
  logic [PW-1:0] trigPin = '0;
  logic          serviceReq = 1'b0;
  logic [PW-1:0] tblIdx;
  logic [63:0]   tblEntry;
  logic [63:0]   entryView;
  logic [NP-1:0] pendingOut;
  logic          msgValid;
  logic          msgReady = 1'b0;
  logic [7:0]    msgDest;
  logic          msgDestMode;
  logic [2:0]    msgDelMode;
  logic [7:0]    msgVector;
  logic          msgPolarity;
  logic          msgTrigMode;

  logic [63:0]   tbl [NP];
  logic [NP-1:0] model = '0;
  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int dlvCount = 0;
  int dlvPin [8];
  int dlvCyc [8];
  bit seen [NP];

  always #4 clk = ~clk;

  assign tblEntry = (32'(tblIdx) < NP) ? tbl[tblIdx] : 64'h0;

  irq_dispatch #(.NUM_PINS(NP), .PIN_W(PW)) uut (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigPin(trigPin),
    .serviceReq(serviceReq), .tblIdx(tblIdx), .tblEntry(tblEntry),
    .entryView(entryView), .pendingOut(pendingOut), .msgValid(msgValid),
    .msgReady(msgReady), .msgDest(msgDest), .msgDestMode(msgDestMode),
    .msgDelMode(msgDelMode), .msgVector(msgVector), .msgPolarity(msgPolarity),
    .msgTrigMode(msgTrigMode)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkEntry(input int pin, input bit masked);
    logic [63:0] e;
    e = {$urandom(), $urandom()};
    e[7:0] = 8'h40 + 8'(pin);
    e[16]  = masked;
    return e;
  endfunction

  // one clock: observe at the negedge, drive, then advance to the next negedge
  task automatic step(input bit tv, input logic [PW-1:0] tp, input bit sv);
    logic [NP-1:0] nxt;
    int p;
    nxt = model;
    chk(entryView == (tblEntry & ~(64'd1 << 12)), "R10", entryView, tblEntry & ~(64'd1 << 12));
    if (msgValid) begin
      p = int'(msgVector) - 'h40;
      chk(p >= 0 && p < NP, "R6 vector", 64'(msgVector), 64'h40);
      if (p >= 0 && p < NP) begin
        chk(model[p] && !tbl[p][16], "R7 offered pin pending and unmasked", 64'(p), 64'(model));
        chk({msgDest, msgDestMode, msgDelMode, msgPolarity, msgTrigMode} ==
            {tbl[p][63:56], tbl[p][11], tbl[p][10:8], tbl[p][13], tbl[p][15]},
            "R6 fields", {msgDest, msgDestMode, msgDelMode, msgPolarity, msgTrigMode},
            {tbl[p][63:56], tbl[p][11], tbl[p][10:8], tbl[p][13], tbl[p][15]});
        if (msgReady) begin
          nxt[p] = 1'b0;
          seen[p] = 1'b1;
          if (dlvCount < 8) begin
            dlvPin[dlvCount] = p;
            dlvCyc[dlvCount] = cyc;
          end
          dlvCount++;
        end
      end
    end
    trigValid = tv; trigPin = tp; serviceReq = sv;
    if (tv && 32'(tp) < NP) nxt[tp] = 1'b1;
    model = nxt;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    trigValid = 1'b0; serviceReq = 1'b0;
    chk(pendingOut == model, "R2/R8/R9 pending", 64'(pendingOut), 64'(model));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  task automatic clearSeen();
    for (int i = 0; i < NP; i++) seen[i] = 1'b0;
    dlvCount = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int n0;
    int vcount;
    logic [NP-1:0] snap;
    logic [NP-1:0] maskSet;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) tbl[i] = mkEntry(i, 1'b0);
    clearSeen();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pendingOut == '0, "R1 pending", 64'(pendingOut), 0);
    chk(!msgValid, "R1 valid", 64'(msgValid), 0);

    // R8: refused offers stay pending; then R4 order and timing
    msgReady = 1'b0;
    step(1'b1, 5'd9, 1'b0);  idle(60);
    step(1'b1, 5'd2, 1'b0);  idle(60);
    step(1'b1, 5'd17, 1'b0); idle(60);
    chk(pendingOut == ((24'd1 << 2) | (24'd1 << 9) | (24'd1 << 17)), "R8 refused kept",
        64'(pendingOut), 64'h20204);
    msgReady = 1'b1;
    clearSeen();
    n0 = cyc;
    step(1'b0, '0, 1'b1);
    idle(60);
    chk(dlvCount == 3, "R4 delivery count", 64'(dlvCount), 3);
    chk(dlvPin[0] == 2 && dlvPin[1] == 9 && dlvPin[2] == 17, "R4 ascending order",
        64'(dlvPin[0] * 10000 + dlvPin[1] * 100 + dlvPin[2]), 64'(20917));
    chk(dlvCyc[0] - n0 == 4 && dlvCyc[1] - n0 == 12 && dlvCyc[2] - n0 == 21, "R4 one pin per cycle",
        64'((dlvCyc[0] - n0) * 10000 + (dlvCyc[1] - n0) * 100 + (dlvCyc[2] - n0)), 64'(41221));
    chk(pendingOut == '0, "R8 accepted cleared", 64'(pendingOut), 0);

    // R7: masked pin kept; R2: re-trigger of set pin changes nothing
    tbl[4][16] = 1'b1;
    clearSeen();
    step(1'b1, 5'd4, 1'b0); idle(40);
    step(1'b1, 5'd4, 1'b1); idle(40);
    chk(!seen[4] && pendingOut[4], "R7 masked kept", 64'(pendingOut), 64'h10);
    chk(pendingOut == 24'h10, "R2 re-trigger", 64'(pendingOut), 64'h10);

    // R3: out-of-range pin changes nothing and starts no pass
    snap = pendingOut;
    vcount = 0;
    step(1'b1, 5'd27, 1'b0);
    for (int i = 0; i < 40; i++) begin
      if (msgValid) vcount++;
      step(1'b0, '0, 1'b0);
    end
    chk(pendingOut == snap, "R3 pending unchanged", 64'(pendingOut), 64'(snap));
    chk(vcount == 0, "R3 no pass", 64'(vcount), 0);

    // R5: service request mid-pass forces another pass
    tbl[1][16] = 1'b1;
    step(1'b1, 5'd1, 1'b0); idle(40);
    clearSeen();
    step(1'b1, 5'd0, 1'b0);
    idle(5);
    tbl[1][16] = 1'b0;
    step(1'b0, '0, 1'b1);
    idle(70);
    chk(seen[1] && !pendingOut[1], "R5 rerun delivers", 64'(pendingOut), 64'h10);

    // R9: trigger in the cycle of acceptance keeps the flag
    clearSeen();
    step(1'b1, 5'd6, 1'b0);
    for (int i = 0; i < 40; i++) begin
      if (msgValid && msgVector == 8'h46) step(1'b1, 5'd6, 1'b0);
      else step(1'b0, '0, 1'b0);
    end
    chk(seen[6] && pendingOut[6], "R9 set wins", 64'(pendingOut), 64'h50);
    step(1'b0, '0, 1'b1); idle(40);
    chk(!pendingOut[6], "R9 later drained", 64'(pendingOut), 64'h10);

    // random traffic with random masks and acceptance
    maskSet = '0;
    for (int i = 0; i < NP; i++) begin
      tbl[i] = mkEntry(i, ($urandom() % 4) == 0);
      maskSet[i] = tbl[i][16];
    end
    for (int i = 0; i < 1500; i++) begin
      msgReady = $urandom() % 2;
      step(($urandom() % 4) == 0, PW'($urandom()), ($urandom() % 16) == 0);
    end
    // R11: drain with ready held high
    msgReady = 1'b1;
    step(1'b0, '0, 1'b1);
    idle(100);
    chk(pendingOut == (model & maskSet), "R11 drain", 64'(pendingOut), 64'(model & maskSet));
    chk((pendingOut & ~maskSet) == '0, "R11 only masked left", 64'(pendingOut), 64'(maskSet));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule